// File: doc/BRIEF.md
# Multi-Channel Hit Buffer Readout Controller

The block records, once per system clock while recording runs, a 6-bit rising-edge code and a 6-bit falling-edge code for each input channel into a shared buffer, one word per clock covering all channels. Each code carries a hit tag in bit 5 and a transition position in bits 4:0. Two 7-bit loadable pointers address the buffer. The write pointer steps once per stored word. The read pointer either follows recording clock by clock or steps after each pulse of an external read clock. Both pointers, plus two control bits, are reachable through a small control-register port with an active-low data bus.

Readout runs in one of four modes. Two are synchronous: a word is fetched every system clock while reading runs, either with individual tags or with tags OR-merged into channel 0 and channel 1. Two are asynchronous: a word is fetched on each rising edge of the read clock, after a synchronizer, for all channels or for one selected channel. Every read word comes out together with the read pointer it came from. Per-channel output enables and a pointer enable are plain outputs. A pulsed-tag option shows the tag bits only in the cycle a word is fetched.

Top module: `hit_buf_ctrl`

## Requirements
- R1: After reset both pointers, both control bits, the run flags, the write strobe, the data outputs and the pointer output are all zero.
- R2: A high `wr_start_i` sampled on a clock edge sets `wr_run_o` on that edge. Each following edge with `wr_run_o` high stores {fall codes, rise codes} at the write pointer and increments the pointer modulo 128. `wr_strobe_o` is high for the one cycle after each store.
- R3: The control port writes on a clock edge with `csr_cs_i`=1 and `csr_rd_i`=0, and reads combinationally. Both data buses are active low. Address 0 holds the control bits: bit 0 is hold and bit 1 is auto-advance. Address 1 is the read pointer, address 2 is the write pointer, and address 3 reads zero. A pointer write takes priority over an increment.
- R4: In modes 0 and 1, a high `rd_start_i` sampled on an edge sets `rd_run_o`. Every edge with `rd_run_o` high fetches the word at the read pointer to the data outputs and puts that pointer on `rptr_o`.
- R5: In modes 0 and 1, the read pointer increments on every edge that stores a word, unless the hold bit is 1. With the hold bit set it stays where it is.
- R6: Mode 1 changes three tags. Channel 0's rising tag (rise bit 5) is the OR of all rising tags. Channel 0's falling tag is the OR of all falling tags. Channel 1's rising tag (rise bit 11) is the OR of all eight tags. Mode 0 passes each tag unchanged.
- R7: In modes 2 and 3, `rd_run_o` is high. A rising `rd_clk_i` fetches the word at the read pointer on the third clock edge after it. A falling `rd_clk_i` increments the read pointer on the third edge after it, but only if auto-advance is 1.
- R8: With `rd_en_ni` high, `data_en_o` and `rptr_en_o` are zero. With it low, `rptr_en_o` is 1. In mode 3 only bit `ch_sel_i` of `data_en_o` is set; in the other modes all bits are set.
- R9: With `tag_pulse_i`=1 the tag bits are visible only in the cycle right after a fetch and read zero otherwise. With `tag_pulse_i`=0 they are held with the data.
- R10: The channel n code sits in bits [6n+5:6n] of the rise and fall buses, with bit 6n+5 as the tag. The encoding of mode_i is: 0 = sync individual, 1 = sync merged, 2 = async all, 3 = async one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rise_code_i | input | 24 | Rising-edge codes, 6 bits per channel |
| fall_code_i | input | 24 | Falling-edge codes, 6 bits per channel |
| wr_start_i | input | 1 | Recording start level |
| wr_run_o | output | 1 | Recording active |
| wr_strobe_o | output | 1 | One pulse per stored word |
| rd_start_i | input | 1 | Synchronous readout start level |
| rd_run_o | output | 1 | Readout active |
| mode_i | input | 2 | Readout mode |
| ch_sel_i | input | 2 | Channel picked in mode 3 |
| rd_clk_i | input | 1 | External read clock for async modes |
| rd_en_ni | input | 1 | Output enable, active low |
| tag_pulse_i | input | 1 | 1 = pulsed tags, 0 = level tags |
| rise_data_o | output | 24 | Read rising codes |
| fall_data_o | output | 24 | Read falling codes |
| data_en_o | output | 4 | Per-channel data enable |
| rptr_o | output | 7 | Read pointer of the current word |
| rptr_en_o | output | 1 | Pointer output enable |
| csr_cs_i | input | 1 | Control port strobe |
| csr_rd_i | input | 1 | 1 = read, 0 = write |
| csr_addr_i | input | 2 | Register address |
| csr_wdata_ni | input | 8 | Write data, active low |
| csr_rdata_no | output | 8 | Read data, active low |

## Verification
The bench builds the block with its defaults: four channels and a 7-bit address, so 128 words. With only 128 words, preloading the write pointer to 120 makes the wrap from 127 to 0 happen within the first recording burst. The same wrapped region is then read back in all four modes. Four channels are enough to place a lone falling tag on channel 3 and see it reach the merged tags of channels 0 and 1. The 2-bit channel select is also driven to a value other than zero.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int CODE_W = 6;
  localparam int CSR_W  = 8;

  typedef enum logic [1:0] {
    MODE_SYNC_IND  = 2'd0,
    MODE_SYNC_OR   = 2'd1,
    MODE_ASYNC_ALL = 2'd2,
    MODE_ASYNC_ONE = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    CSR_CTRL = 2'd0,
    CSR_RPTR = 2'd1,
    CSR_WPTR = 2'd2,
    CSR_NONE = 2'd3
  } csr_addr_e;
endpackage

// File: rtl/hbr_ptr.sv
module hbr_ptr #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= q_o + AW'(1);
  end

  // R3
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(load_val_i));

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i) |=> q_o == $past(q_o) + AW'(1));
endmodule

// File: rtl/hbr_edge_det.sv
module hbr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      dly_q  <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  assign rise_o = sync_q & ~dly_q;
  assign fall_o = ~sync_q & dly_q;

  // R7
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hbr_tag_merge.sv
module hbr_tag_merge #(
  parameter int NCH = 4,
  parameter int CW  = 6
) (
  input  logic [NCH*CW-1:0] rise_i,
  input  logic [NCH*CW-1:0] fall_i,
  input  logic              merge_i,
  input  logic              show_i,
  output logic [NCH*CW-1:0] rise_o,
  output logic [NCH*CW-1:0] fall_o
);
  logic [NCH-1:0] rt, ft;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_tag
    assign rt[ch] = rise_i[ch*CW+CW-1] & show_i;
    assign ft[ch] = fall_i[ch*CW+CW-1] & show_i;
  end

  always_comb begin
    rise_o = rise_i;
    fall_o = fall_i;
    for (int ch = 0; ch < NCH; ch++) begin
      rise_o[ch*CW+CW-1] = rt[ch];
      fall_o[ch*CW+CW-1] = ft[ch];
    end
    if (merge_i) begin
      rise_o[CW-1]   = |rt;
      fall_o[CW-1]   = |ft;
      rise_o[2*CW-1] = (|rt) | (|ft);
    end
  end
endmodule

// File: rtl/hit_buf_ctrl.sv
module hit_buf_ctrl
  import hbr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH*CODE_W-1:0]   rise_code_i,
  input  logic [NUM_CH*CODE_W-1:0]   fall_code_i,
  input  logic                       wr_start_i,
  output logic                       wr_run_o,
  output logic                       wr_strobe_o,
  input  logic                       rd_start_i,
  output logic                       rd_run_o,
  input  logic [1:0]                 mode_i,
  input  logic [$clog2(NUM_CH)-1:0]  ch_sel_i,
  input  logic                       rd_clk_i,
  input  logic                       rd_en_ni,
  input  logic                       tag_pulse_i,
  output logic [NUM_CH*CODE_W-1:0]   rise_data_o,
  output logic [NUM_CH*CODE_W-1:0]   fall_data_o,
  output logic [NUM_CH-1:0]          data_en_o,
  output logic [ADDR_W-1:0]          rptr_o,
  output logic                       rptr_en_o,
  input  logic                       csr_cs_i,
  input  logic                       csr_rd_i,
  input  logic [1:0]                 csr_addr_i,
  input  logic [CSR_W-1:0]           csr_wdata_ni,
  output logic [CSR_W-1:0]           csr_rdata_no
);
  localparam int SEL_W   = $clog2(NUM_CH);
  localparam int CH_BITS = NUM_CH * CODE_W;
  localparam int WORD_W  = 2 * CH_BITS;
  localparam int DEPTH   = 1 << ADDR_W;

  rd_mode_e mode;
  logic     async_mode;
  assign mode       = rd_mode_e'(mode_i);
  assign async_mode = (mode == MODE_ASYNC_ALL) || (mode == MODE_ASYNC_ONE);

  // control port decode
  logic             csr_wr, ctrl_ld, rp_ld, wp_ld;
  logic [CSR_W-1:0] csr_wval, csr_rval;
  logic             unused_csr_bits;
  assign csr_wr   = csr_cs_i & ~csr_rd_i;
  assign csr_wval = ~csr_wdata_ni;
  assign ctrl_ld  = csr_wr && (csr_addr_i == CSR_CTRL);
  assign rp_ld    = csr_wr && (csr_addr_i == CSR_RPTR);
  assign wp_ld    = csr_wr && (csr_addr_i == CSR_WPTR);
  assign unused_csr_bits = ^csr_wval[CSR_W-1:ADDR_W];

  logic rp_hold_q, auto_adv_q;
  logic wr_run_q, wr_strobe_q, rd_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_hold_q   <= 1'b0;
      auto_adv_q  <= 1'b0;
      wr_run_q    <= 1'b0;
      wr_strobe_q <= 1'b0;
      rd_run_q    <= 1'b0;
    end else begin
      if (ctrl_ld) begin
        rp_hold_q  <= csr_wval[0];
        auto_adv_q <= csr_wval[1];
      end
      wr_run_q    <= wr_start_i;
      wr_strobe_q <= wr_run_q;
      rd_run_q    <= async_mode | rd_start_i;
    end
  end

  // read clock synchronizer
  logic rclk_rise, rclk_fall;
  hbr_edge_det u_rclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rd_clk_i),
    .rise_o (rclk_rise),
    .fall_o (rclk_fall)
  );

  // pointers
  logic [ADDR_W-1:0] wp, rp;
  logic              rp_inc;
  assign rp_inc = async_mode ? (rclk_fall & auto_adv_q) : (wr_run_q & ~rp_hold_q);

  hbr_ptr #(.AW(ADDR_W)) u_wptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wp_ld),
    .load_val_i (csr_wval[ADDR_W-1:0]),
    .inc_i      (wr_run_q),
    .q_o        (wp)
  );

  hbr_ptr #(.AW(ADDR_W)) u_rptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rp_ld),
    .load_val_i (csr_wval[ADDR_W-1:0]),
    .inc_i      (rp_inc),
    .q_o        (rp)
  );

  // buffer
  logic [WORD_W-1:0] mem_q [DEPTH];
  always_ff @(posedge clk_i) begin
    if (wr_run_q) mem_q[wp] <= {fall_code_i, rise_code_i};
  end

  // read stage
  logic              fetch, pulse_q;
  logic [WORD_W-1:0] out_q;
  logic [ADDR_W-1:0] rp_out_q;
  assign fetch = rd_run_q & (async_mode ? rclk_rise : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      rp_out_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= fetch;
      if (fetch) begin
        out_q    <= mem_q[rp];
        rp_out_q <= rp;
      end
    end
  end

  hbr_tag_merge #(.NCH(NUM_CH), .CW(CODE_W)) u_merge (
    .rise_i  (out_q[CH_BITS-1:0]),
    .fall_i  (out_q[WORD_W-1:CH_BITS]),
    .merge_i (mode == MODE_SYNC_OR),
    .show_i  (~tag_pulse_i | pulse_q),
    .rise_o  (rise_data_o),
    .fall_o  (fall_data_o)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_en
    assign data_en_o[ch] = ~rd_en_ni &
                           ((mode != MODE_ASYNC_ONE) || (ch_sel_i == SEL_W'(ch)));
  end

  always_comb begin
    case (csr_addr_i)
      CSR_CTRL: csr_rval = CSR_W'({auto_adv_q, rp_hold_q});
      CSR_RPTR: csr_rval = CSR_W'(rp);
      CSR_WPTR: csr_rval = CSR_W'(wp);
      default:  csr_rval = '0;
    endcase
  end

  assign csr_rdata_no = ~csr_rval;
  assign wr_run_o     = wr_run_q;
  assign wr_strobe_o  = wr_strobe_q;
  assign rd_run_o     = rd_run_q;
  assign rptr_o       = rp_out_q;
  assign rptr_en_o    = ~rd_en_ni;

  // R2
  wr_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_i |=> wr_run_o);

  // R4
  rd_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_i |=> rd_run_o);

  // R5
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rp_hold_q && !async_mode && !rp_ld) |=> $stable(rp));

  // R7
  async_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_mode && !auto_adv_q && !rp_ld) |=> $stable(rp));

  // R8
  one_ch_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_ASYNC_ONE && !rd_en_ni) |-> $countones(data_en_o) == 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pulse_chk
    // R9
    tag_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tag_pulse_i && !pulse_q) |->
        !rise_data_o[ch*CODE_W+CODE_W-1] && !fall_data_o[ch*CODE_W+CODE_W-1]);
  end
endmodule

// File: tb/hit_buf_ctrl_bench.sv
module hit_buf_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [23:0] rise_code, fall_code;
  logic        wr_start, wr_run, wr_strobe, rd_start, rd_run;
  logic [1:0]  mode, ch_sel;
  logic        rd_clk, rd_en_n, tag_pulse;
  logic [23:0] rise_data, fall_data;
  logic [3:0]  data_en;
  logic [6:0]  rptr;
  logic        rptr_en;
  logic        csr_cs, csr_rd;
  logic [1:0]  csr_addr;
  logic [7:0]  csr_wdata_n, csr_rdata_n;

  int          test_cnt = 0;
  int          fail_cnt = 0;
  int          strobe_cnt = 0;
  bit          done = 0;
  logic [47:0] mdl [128];

  always #5 clk = ~clk;

  hit_buf_ctrl u_hit_buf_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .rise_code_i(rise_code), .fall_code_i(fall_code),
    .wr_start_i(wr_start), .wr_run_o(wr_run), .wr_strobe_o(wr_strobe),
    .rd_start_i(rd_start), .rd_run_o(rd_run),
    .mode_i(mode), .ch_sel_i(ch_sel), .rd_clk_i(rd_clk),
    .rd_en_ni(rd_en_n), .tag_pulse_i(tag_pulse),
    .rise_data_o(rise_data), .fall_data_o(fall_data),
    .data_en_o(data_en), .rptr_o(rptr), .rptr_en_o(rptr_en),
    .csr_cs_i(csr_cs), .csr_rd_i(csr_rd), .csr_addr_i(csr_addr),
    .csr_wdata_ni(csr_wdata_n), .csr_rdata_no(csr_rdata_n)
  );

  always @(negedge clk) if (rst_ni && wr_strobe) strobe_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    test_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", test_cnt, fail_cnt);
      $finish;
    end
  endtask

  // R6 R9 R10 expected tag handling
  function automatic logic [23:0] exp_rise(logic [47:0] w, logic [1:0] m, bit show);
    logic [23:0] r, f;
    logic any_r, any_f;
    r = w[23:0]; f = w[47:24]; any_r = 1'b0; any_f = 1'b0;
    for (int c = 0; c < 4; c++) begin
      if (!show) begin r[6*c+5] = 1'b0; f[6*c+5] = 1'b0; end
      any_r |= r[6*c+5];
      any_f |= f[6*c+5];
    end
    if (m == 2'd1) begin r[5] = any_r; r[11] = any_r | any_f; end
    return r;
  endfunction

  function automatic logic [23:0] exp_fall(logic [47:0] w, logic [1:0] m, bit show);
    logic [23:0] f;
    logic any_f;
    f = w[47:24]; any_f = 1'b0;
    for (int c = 0; c < 4; c++) begin
      if (!show) f[6*c+5] = 1'b0;
      any_f |= f[6*c+5];
    end
    if (m == 2'd1) f[5] = any_f;
    return f;
  endfunction

  task automatic csr_wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    csr_cs = 1'b1; csr_rd = 1'b0; csr_addr = a; csr_wdata_n = ~v;
    @(negedge clk);
    csr_cs = 1'b0; csr_wdata_n = 8'hFF;
  endtask

  task automatic csr_get(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    csr_cs = 1'b1; csr_rd = 1'b1; csr_addr = a;
    #1 v = ~csr_rdata_n;
    csr_cs = 1'b0; csr_rd = 1'b0;
  endtask

  task automatic peek(input logic [6:0] a, input logic [1:0] m);
    csr_wr(2'd1, {1'b0, a});
    mode = m;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk($sformatf("R4 rise word @%0d", a), rise_data, exp_rise(mdl[a], m, 1'b1));
    chk($sformatf("R6 fall word @%0d", a), fall_data, exp_fall(mdl[a], m, 1'b1));
    chk("R4 pointer beside word", rptr, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    fail_cnt++; test_cnt++;
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd7741));
    rst_ni = 1'b0; rise_code = '0; fall_code = '0; wr_start = 1'b0; rd_start = 1'b0;
    mode = 2'd0; ch_sel = 2'd0; rd_clk = 1'b0; rd_en_n = 1'b1; tag_pulse = 1'b0;
    csr_cs = 1'b0; csr_rd = 1'b0; csr_addr = 2'd0; csr_wdata_n = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state
    chk("R1 wr_run", wr_run, 0);
    chk("R1 rd_run", rd_run, 0);
    chk("R1 strobe", wr_strobe, 0);
    chk("R1 rise data", rise_data, 0);
    chk("R1 rptr", rptr, 0);
    csr_get(2'd1, v); chk("R1 read pointer", v, 0);
    csr_get(2'd2, v); chk("R1 write pointer", v, 0);
    csr_get(2'd0, v); chk("R1 control", v, 0);

    // R3 preload pointers near the top, hold read pointer
    csr_wr(2'd2, 8'd120);
    csr_wr(2'd1, 8'd120);
    csr_wr(2'd0, 8'd1);
    csr_get(2'd2, v); chk("R3 write pointer load", v, 120);
    csr_get(2'd3, v); chk("R3 spare address", v, 0);

    // R2 record 16 words across the wrap
    @(negedge clk) wr_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 wr_run asserted", wr_run, 1);
    for (int i = 0; i < 16; i++) begin
      rise_code = 24'($urandom);
      fall_code = 24'($urandom);
      if (i == 1) begin
        rise_code = rise_code & ~24'h820820;
        fall_code = (fall_code & ~24'h820820) | 24'h800000;
      end
      if (i == 15) wr_start = 1'b0;
      mdl[7'(120 + i)] = {fall_code, rise_code};
      @(posedge clk);
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk("R2 wr_run released", wr_run, 0);
    chk("R2 strobe count", strobe_cnt, 16);
    csr_get(2'd2, v); chk("R2 write pointer wrapped", v, 8);
    csr_get(2'd1, v); chk("R5 held read pointer", v, 120);

    // R4 R6 directed peeks in sync modes
    rd_start = 1'b1;
    rd_en_n = 1'b0;
    peek(7'd121, 2'd1);
    chk("R6 lone ch3 fall tag merged", {rise_data[11], rise_data[5], fall_data[5]}, 3'b101);
    chk("R4 rd_run", rd_run, 1);
    peek(7'd120, 2'd0);
    peek(7'd127, 2'd1);
    peek(7'd0, 2'd0);
    peek(7'd7, 2'd1);
    chk("R8 sync enables", {rptr_en, data_en}, 5'b11111);

    // R5 read pointer tracks recording
    csr_wr(2'd0, 8'd0);
    csr_wr(2'd1, 8'd120);
    mode = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk) wr_start = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      begin
        logic [6:0] idx;
        idx = (k == 0) ? 7'd120 : 7'(119 + k);
        chk("R5 tracked word", rise_data, exp_rise(mdl[idx], 2'd0, 1'b1));
        chk("R5 tracked pointer", rptr, idx);
      end
      rise_code = 24'($urandom);
      fall_code = 24'($urandom);
      mdl[7'(8 + k)] = {fall_code, rise_code};
      if (k == 5) wr_start = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    chk("R5 last tracked word", fall_data, exp_fall(mdl[125], 2'd0, 1'b1));
    repeat (2) @(posedge clk);
    csr_get(2'd1, v); chk("R5 read pointer after tracking", v, 126);
    csr_get(2'd2, v); chk("R2 write pointer after burst", v, 14);

    // random peeks over recorded region
    for (int n = 0; n < 6; n++) begin
      logic [6:0] a;
      a = 7'(120 + ($urandom % 22));
      peek(a, 2'($urandom % 2));
    end
    rd_start = 1'b0;

    // R7 R8 R9 async single channel, pulsed tags, auto-advance
    csr_wr(2'd0, 8'd3);
    csr_wr(2'd1, 8'd124);
    mode = 2'd3; ch_sel = 2'd2; tag_pulse = 1'b1;
    @(negedge clk);
    chk("R7 async rd_run", rd_run, 1);
    chk("R8 single channel enable", {rptr_en, data_en}, 5'b10100);
    rd_clk = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 pulse tags visible", rise_data, exp_rise(mdl[124], 2'd3, 1'b1));
    chk("R7 async pointer", rptr, 124);
    @(negedge clk);
    chk("R9 pulse tags cleared rise", rise_data, exp_rise(mdl[124], 2'd3, 1'b0));
    chk("R9 pulse tags cleared fall", fall_data, exp_fall(mdl[124], 2'd3, 1'b0));
    rd_clk = 1'b0;
    repeat (4) @(posedge clk);
    csr_get(2'd1, v); chk("R7 auto-advance", v, 125);

    tag_pulse = 1'b0;
    @(negedge clk) rd_clk = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 level tags held", fall_data, exp_fall(mdl[125], 2'd3, 1'b1));
    rd_clk = 1'b0;
    repeat (4) @(posedge clk);

    // R7 R8 async all channels, no auto-advance
    csr_wr(2'd0, 8'd1);
    mode = 2'd2;
    @(negedge clk);
    chk("R8 all channel enable", data_en, 4'hF);
    rd_clk = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R7 async all word", rise_data, exp_rise(mdl[126], 2'd2, 1'b1));
    rd_clk = 1'b0;
    repeat (4) @(posedge clk);
    csr_get(2'd1, v); chk("R7 no auto-advance", v, 126);

    rd_en_n = 1'b1;
    @(negedge clk);
    chk("R8 outputs disabled", {rptr_en, data_en}, 5'b00000);

    finish_run();
  end
endmodule